// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block sits beside a two-bank SDRAM and observes its control pins. At every rising clock edge it decodes the command formed by chip select, RAS, CAS and WE. It keeps its own copy of the state of each bank and of the device, and raises a flag whenever the sampled command is not allowed in that state. It never drives the memory and never touches the data bus. It is meant as a protocol watchdog: placed next to a memory controller, it reports sequencing errors as they happen.

A bank is idle, active or in write recovery. A bank enters write recovery after a write with auto-precharge. The device as a whole can be in a refresh recovery window, in a mode-register recovery window, or in low power. Each recovery window ends on its own parameterised cycle count. Bit A11 addresses a bank. Bit A10 requests auto-precharge on reads and writes, and selects all banks on a precharge. An external strap indicates whether the memory is configured for full-page bursts.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With csN high the command is deselect (code 0). With csN low, {rasN,casN,weN} decodes as follows: 111 no-operation (1), 110 burst stop (2), 101 read (3), 100 write (4), 011 activate (5), 010 precharge (6), 001 refresh (7), 000 mode-register set (8). The code appears on cmdOut after the edge that samples the command.
- R2: Activate is legal only when the bank selected by addrBank is idle (bankState code 0). A legal activate makes that bank active (code 1).
- R3: Read and write are legal only when the selected bank is active. A legal read with addrAp high returns the bank to idle.
- R4: Precharge with addrAp low closes the selected bank. Precharge with addrAp high closes both banks. A precharge is illegal if any bank it targets is in write recovery.
- R5: A legal write with addrAp high puts the selected bank into write recovery (code 2). The bank is judged as recovering at the next DAL_CYC-1 edges and is idle from the DAL_CYC-th edge onward. Commands to the other bank are judged by that bank's own state.
- R6: Refresh and mode-register set are legal only when both banks are idle.
- R7: After a legal refresh, only deselect, no-operation and burst stop are legal at the next RP_CYC-1 edges. busy is high for exactly that window.
- R8: After a legal mode-register set, the same restriction and busy indication apply for the next MCD_CYC-1 edges.
- R9: Burst stop is legal exactly when fullPage is high, in every state.
- R10: Low power is entered when cke is sampled low while both banks are idle and no recovery window is running. It is left at the first edge that samples cke high. Every command sampled at the entry edge, during low power and at the exit edge is ignored: no flag, cmdOut reads deselect, no state change, and busy is high while in low power. A low cke with a bank open does not enter low power.
- R11: An illegal command gives illegalPulse high for the cycle after its edge, with illegalCode holding its command code. It changes no bank or device state.
- R12: After reset, cmdOut and illegalCode read deselect, illegalPulse and busy are low, and both banks are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock; all inputs sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable pin of the memory |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| addrBank | input | 1 | Bank address bit (A11) |
| addrAp | input | 1 | Auto-precharge / all-bank bit (A10) |
| fullPage | input | 1 | High when the memory burst length is full page |
| cmdOut | output | 4 | Decoded command of the last sampled edge |
| bankState | output | 4 | Two bits per bank, bank 0 in [1:0]: 0 idle, 1 active, 2 write recovery |
| illegalPulse | output | 1 | One-cycle flag for an illegal command |
| illegalCode | output | 4 | Code of the offending command |
| busy | output | 1 | Refresh or mode-register recovery running, or low power |

## Verification
bankState and busy are direct copies of the internal state registers. A wrong transition therefore shows at the ports one cycle after the edge that caused it. A stale recovery counter is subtler: it shows up only as a misjudged command, either a missing or a spurious illegalPulse, at the boundary edge of the window. For this reason the directed tests place commands on the last restricted edge and on the first free edge of every window. A low-power entry that is missed surfaces at once as a non-deselect cmdOut on an edge where cke was low.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  localparam int BANKS = 2;

  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_WREC   = 2'd2
  } bank_e;

  // strobes from the legality control into the state tracker
  typedef struct packed {
    logic [BANKS-1:0] openBank;
    logic [BANKS-1:0] closeBank;
    logic [BANKS-1:0] wrApBank;
    logic             startRef;
    logic             startMrs;
    logic             enterLp;
  } strobe_t;

  function automatic cmd_e decodeCmd(input logic csN, input logic rasN,
                                     input logic casN, input logic weN);
    cmd_e c;
    if (csN) begin
      c = CMD_DESL;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  c = CMD_NOP;
        3'b110:  c = CMD_BST;
        3'b101:  c = CMD_READ;
        3'b100:  c = CMD_WRITE;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b001:  c = CMD_REF;
        default: c = CMD_MRS;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank
  import sdram_mon_pkg::*;
#(
  parameter int DAL_CYC = 4,
  parameter int CNT_W   = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       openStb,
  input  logic       closeStb,
  input  logic       wrApStb,
  output logic [1:0] state
);

  bank_e             stateQ;
  logic [CNT_W-1:0]  recCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= BK_IDLE;
      recCnt <= '0;
    end else if (wrApStb) begin
      if (DAL_CYC <= 1) begin
        stateQ <= BK_IDLE;
        recCnt <= '0;
      end else begin
        stateQ <= BK_WREC;
        recCnt <= CNT_W'(DAL_CYC - 1);
      end
    end else if (openStb) begin
      stateQ <= BK_ACTIVE;
    end else if (closeStb) begin
      stateQ <= BK_IDLE;
    end else if (stateQ == BK_WREC) begin
      if (recCnt <= CNT_W'(1)) begin
        stateQ <= BK_IDLE;
        recCnt <= '0;
      end else begin
        recCnt <= recCnt - CNT_W'(1);
      end
    end
  end

  assign state = stateQ;

endmodule

// File: rtl/sdram_mon_track.sv
module sdram_mon_track
  import sdram_mon_pkg::*;
#(
  parameter int DAL_CYC = 4,
  parameter int RP_CYC  = 3,
  parameter int MCD_CYC = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cke,
  input  strobe_t               stb,
  output logic [BANKS-1:0][1:0] bankSt,
  output logic                  devBusy,
  output logic                  lowPower
);

  localparam int MAX_A   = (DAL_CYC > RP_CYC) ? DAL_CYC : RP_CYC;
  localparam int MAX_CYC = (MAX_A > MCD_CYC) ? MAX_A : MCD_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] devCnt;
  logic             lowPowerQ;

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    sdram_mon_bank #(
      .DAL_CYC(DAL_CYC),
      .CNT_W  (CNT_W)
    ) i_bank (
      .clk     (clk),
      .rstN    (rstN),
      .openStb (stb.openBank[g]),
      .closeStb(stb.closeBank[g]),
      .wrApStb (stb.wrApBank[g]),
      .state   (bankSt[g])
    );
  end

  // device-wide recovery window after refresh or mode-register set
  always_ff @(posedge clk) begin
    if (!rstN) begin
      devCnt <= '0;
    end else if (stb.startRef) begin
      devCnt <= CNT_W'(RP_CYC - 1);
    end else if (stb.startMrs) begin
      devCnt <= CNT_W'(MCD_CYC - 1);
    end else if (devCnt != '0) begin
      devCnt <= devCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowPowerQ <= 1'b0;
    end else begin
      lowPowerQ <= stb.enterLp | (lowPowerQ & ~cke);
    end
  end

  assign devBusy  = (devCnt != '0);
  assign lowPower = lowPowerQ;

endmodule

// File: rtl/sdram_mon_ctrl.sv
module sdram_mon_ctrl
  import sdram_mon_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cke,
  input  logic                  csN,
  input  logic                  rasN,
  input  logic                  casN,
  input  logic                  weN,
  input  logic                  addrBank,
  input  logic                  addrAp,
  input  logic                  fullPage,
  input  logic [BANKS-1:0][1:0] bankSt,
  input  logic                  devBusy,
  input  logic                  lowPower,
  output strobe_t               stb,
  output logic [3:0]            cmdOut,
  output logic                  illegalPulse,
  output logic [3:0]            illegalCode
);

  cmd_e       cmd;
  logic [1:0] selSt;
  logic       allIdle;
  logic       anyWrec;
  logic       ignored;
  logic       legal;

  assign cmd = decodeCmd(csN, rasN, casN, weN);

  always_comb begin
    allIdle = 1'b1;
    anyWrec = 1'b0;
    for (int i = 0; i < BANKS; i++) begin
      if (bankSt[i] != BK_IDLE) allIdle = 1'b0;
      if (bankSt[i] == BK_WREC) anyWrec = 1'b1;
    end
    selSt = bankSt[addrBank];
  end

  always_comb begin
    ignored = lowPower | (~cke & allIdle & ~devBusy);
    case (cmd)
      CMD_DESL, CMD_NOP:   legal = 1'b1;
      CMD_BST:             legal = fullPage;
      CMD_READ, CMD_WRITE: legal = ~devBusy & (selSt == BK_ACTIVE);
      CMD_ACT:             legal = ~devBusy & (selSt == BK_IDLE);
      CMD_PRE:             legal = ~devBusy & (addrAp ? ~anyWrec : (selSt != BK_WREC));
      CMD_REF, CMD_MRS:    legal = ~devBusy & allIdle;
      default:             legal = 1'b0;
    endcase
  end

  always_comb begin
    stb         = '0;
    stb.enterLp = ~lowPower & ~cke & allIdle & ~devBusy;
    if (!ignored && legal) begin
      case (cmd)
        CMD_ACT:   stb.openBank[addrBank] = 1'b1;
        CMD_READ:  if (addrAp) stb.closeBank[addrBank] = 1'b1;
        CMD_WRITE: if (addrAp) stb.wrApBank[addrBank] = 1'b1;
        CMD_PRE: begin
          if (addrAp) stb.closeBank = '1;
          else        stb.closeBank[addrBank] = 1'b1;
        end
        CMD_REF:   stb.startRef = 1'b1;
        CMD_MRS:   stb.startMrs = 1'b1;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdOut       <= CMD_DESL;
      illegalPulse <= 1'b0;
      illegalCode  <= CMD_DESL;
    end else begin
      cmdOut       <= ignored ? CMD_DESL : cmd;
      illegalPulse <= ~ignored & ~legal;
      illegalCode  <= (~ignored & ~legal) ? cmd : CMD_DESL;
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int DAL_CYC = 4,
  parameter int RP_CYC  = 3,
  parameter int MCD_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cke,
  input  logic       csN,
  input  logic       rasN,
  input  logic       casN,
  input  logic       weN,
  input  logic       addrBank,
  input  logic       addrAp,
  input  logic       fullPage,
  output logic [3:0] cmdOut,
  output logic [3:0] bankState,
  output logic       illegalPulse,
  output logic [3:0] illegalCode,
  output logic       busy
);

  strobe_t                stb;
  logic [BANKS-1:0][1:0]  bankSt;
  logic                   devBusy;
  logic                   lowPower;

  sdram_mon_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cke         (cke),
    .csN         (csN),
    .rasN        (rasN),
    .casN        (casN),
    .weN         (weN),
    .addrBank    (addrBank),
    .addrAp      (addrAp),
    .fullPage    (fullPage),
    .bankSt      (bankSt),
    .devBusy     (devBusy),
    .lowPower    (lowPower),
    .stb         (stb),
    .cmdOut      (cmdOut),
    .illegalPulse(illegalPulse),
    .illegalCode (illegalCode)
  );

  sdram_mon_track #(
    .DAL_CYC(DAL_CYC),
    .RP_CYC (RP_CYC),
    .MCD_CYC(MCD_CYC)
  ) i_track (
    .clk     (clk),
    .rstN    (rstN),
    .cke     (cke),
    .stb     (stb),
    .bankSt  (bankSt),
    .devBusy (devBusy),
    .lowPower(lowPower)
  );

  assign bankState = bankSt;
  assign busy      = devBusy | lowPower;

endmodule

// File: rtl/sdram_mon_chk.sv
module sdram_mon_chk #(
  parameter int RP_CYC = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       cke,
  input logic       csN,
  input logic       rasN,
  input logic       casN,
  input logic       weN,
  input logic       addrBank,
  input logic       fullPage,
  input logic [3:0] cmdOut,
  input logic [3:0] bankState,
  input logic       illegalPulse,
  input logic [3:0] illegalCode,
  input logic       busy
);

  logic isAct, isRef, isBst, bothIdle, selIdle, lastBank;
  logic [1:0] postSel;

  assign isAct    = ~csN & ~rasN &  casN &  weN;
  assign isRef    = ~csN & ~rasN & ~casN &  weN;
  assign isBst    = ~csN &  rasN &  casN & ~weN;
  assign bothIdle = (bankState == 4'd0);
  assign selIdle  = (addrBank ? bankState[3:2] : bankState[1:0]) == 2'd0;
  assign postSel  = lastBank ? bankState[3:2] : bankState[1:0];

  always_ff @(posedge clk) lastBank <= addrBank;

  AST_ACT_OPENS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (cke && !busy && isAct && selIdle) |=> (postSel == 2'd1)); // R2

  AST_REF_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (cke && isRef && !bothIdle) |=> illegalPulse); // R6

  AST_REF_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ((RP_CYC > 1) && cke && !busy && isRef && bothIdle) |=> busy); // R7

  AST_BST_FULL_PAGE: assert property (@(posedge clk) disable iff (!rstN)
    (isBst && fullPage) |=> !illegalPulse); // R9

  AST_LOW_POWER_IGNORES: assert property (@(posedge clk) disable iff (!rstN)
    (!cke && !busy && bothIdle) |=> (!illegalPulse && cmdOut == 4'd0 && busy)); // R10

  AST_FLAG_NOT_BENIGN: assert property (@(posedge clk) disable iff (!rstN)
    illegalPulse |-> (illegalCode > 4'd1)); // R11

  AST_BANK_ENCODING: assert property (@(posedge clk) disable iff (!rstN)
    (bankState[1:0] != 2'd3) && (bankState[3:2] != 2'd3)); // R12

endmodule

bind sdram_cmd_monitor sdram_mon_chk #(.RP_CYC(RP_CYC)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cke         (cke),
  .csN         (csN),
  .rasN        (rasN),
  .casN        (casN),
  .weN         (weN),
  .addrBank    (addrBank),
  .fullPage    (fullPage),
  .cmdOut      (cmdOut),
  .bankState   (bankState),
  .illegalPulse(illegalPulse),
  .illegalCode (illegalCode),
  .busy        (busy)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
  import sdram_mon_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cke = 1'b1, csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1;
  logic addrBank = 1'b0, addrAp = 1'b0, fullPage = 1'b0;
  logic [3:0] cmdOut, bankState, illegalCode;
  logic illegalPulse, busy;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor i_sdram_cmd_monitor (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .addrBank(addrBank), .addrAp(addrAp), .fullPage(fullPage),
    .cmdOut(cmdOut), .bankState(bankState), .illegalPulse(illegalPulse),
    .illegalCode(illegalCode), .busy(busy)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one command at a falling edge, return after the next falling edge
  task automatic issue(input cmd_e c, input logic b, input logic ap, input logic k = 1'b1);
    cke = k; addrBank = b; addrAp = ap;
    csN = (c == CMD_DESL);
    case (c)
      CMD_NOP:   {rasN, casN, weN} = 3'b111;
      CMD_BST:   {rasN, casN, weN} = 3'b110;
      CMD_READ:  {rasN, casN, weN} = 3'b101;
      CMD_WRITE: {rasN, casN, weN} = 3'b100;
      CMD_ACT:   {rasN, casN, weN} = 3'b011;
      CMD_PRE:   {rasN, casN, weN} = 3'b010;
      CMD_REF:   {rasN, casN, weN} = 3'b001;
      CMD_MRS:   {rasN, casN, weN} = 3'b000;
      default:   {rasN, casN, weN} = 3'b111;
    endcase
    @(negedge clk);
  endtask

  task automatic expectLegal(input string tag, input int code);
    checkEq({tag, " flag"}, illegalPulse, 0);
    checkEq({tag, " cmd"}, cmdOut, code);
  endtask

  task automatic expectIllegal(input string tag, input int code);
    checkEq({tag, " flag"}, illegalPulse, 1);
    checkEq({tag, " code"}, illegalCode, code);
  endtask

  task automatic testReset;
    checkEq("R12 cmdOut", cmdOut, 0);
    checkEq("R12 flag", illegalPulse, 0);
    checkEq("R12 code", illegalCode, 0);
    checkEq("R12 banks", bankState, 0);
    checkEq("R12 busy", busy, 0);
  endtask

  task automatic testDecode;
    issue(CMD_NOP, 0, 0);   expectLegal("R1 nop", 1);
    issue(CMD_DESL, 0, 0);  expectLegal("R1 desl", 0);
    fullPage = 1'b1;
    issue(CMD_BST, 1, 0);   expectLegal("R1 bst", 2);
    fullPage = 1'b0;
    issue(CMD_NOP, 0, 0);
  endtask

  task automatic testBankFlow;
    issue(CMD_READ, 0, 0);  expectIllegal("R3 read idle", 3);
    checkEq("R11 read idle no change", bankState, 0);
    issue(CMD_NOP, 0, 0);   checkEq("R11 single cycle", illegalPulse, 0);
    issue(CMD_ACT, 0, 0);   expectLegal("R2 act", 5);
    checkEq("R2 bank0 active", bankState, 4'b0001);
    issue(CMD_ACT, 0, 0);   expectIllegal("R2 act twice", 5);
    issue(CMD_READ, 0, 0);  expectLegal("R3 read active", 3);
    issue(CMD_WRITE, 1, 0); expectIllegal("R3 write idle bank", 4);
    issue(CMD_PRE, 0, 0);   expectLegal("R4 pre single", 6);
    checkEq("R4 bank0 closed", bankState, 0);
    issue(CMD_ACT, 1, 0);   checkEq("R2 bank1 active", bankState, 4'b0100);
    issue(CMD_READ, 1, 1);  expectLegal("R3 read ap", 3);
    checkEq("R3 read ap closes", bankState, 0);
  endtask

  task automatic testWriteRecovery;
    issue(CMD_ACT, 0, 0);
    issue(CMD_ACT, 1, 0);
    issue(CMD_WRITE, 0, 1); expectLegal("R5 write ap", 4);
    checkEq("R5 bank0 recovering", bankState, 4'b0110);
    issue(CMD_READ, 0, 0);  expectIllegal("R5 read recovering bank", 3);
    issue(CMD_READ, 1, 0);  expectLegal("R5 other bank read", 3);
    issue(CMD_PRE, 1, 1);   expectIllegal("R4 pre all during recovery", 6);
    checkEq("R5 bank0 idle after window", bankState, 4'b0100);
    issue(CMD_REF, 0, 0);   expectIllegal("R6 ref with open bank", 7);
    issue(CMD_PRE, 1, 0);   checkEq("R4 bank1 closed", bankState, 0);
  endtask

  task automatic testRefresh;
    issue(CMD_REF, 0, 0);   expectLegal("R7 ref", 7);
    checkEq("R7 busy set", busy, 1);
    issue(CMD_ACT, 0, 0);   expectIllegal("R7 act in window", 5);
    checkEq("R7 busy held", busy, 1);
    issue(CMD_NOP, 0, 0);   expectLegal("R7 nop in window", 1);
    checkEq("R7 busy cleared", busy, 0);
    issue(CMD_ACT, 0, 0);   expectLegal("R7 act after window", 5);
    checkEq("R7 bank opened", bankState, 4'b0001);
    issue(CMD_MRS, 0, 0);   expectIllegal("R6 mrs with open bank", 8);
    issue(CMD_PRE, 0, 0);
  endtask

  task automatic testModeSet;
    issue(CMD_MRS, 0, 0);   expectLegal("R8 mrs", 8);
    checkEq("R8 busy set", busy, 1);
    issue(CMD_ACT, 1, 0);   expectIllegal("R8 act in window", 5);
    checkEq("R8 busy cleared", busy, 0);
    issue(CMD_ACT, 1, 0);   expectLegal("R8 act after window", 5);
    issue(CMD_PRE, 1, 0);   checkEq("R8 banks idle", bankState, 0);
  endtask

  task automatic testBurstStop;
    fullPage = 1'b0;
    issue(CMD_BST, 0, 0);   expectIllegal("R9 bst not full page", 2);
    fullPage = 1'b1;
    issue(CMD_BST, 0, 0);   expectLegal("R9 bst full page", 2);
    fullPage = 1'b0;
  endtask

  task automatic testLowPower;
    issue(CMD_READ, 0, 0, 1'b0); expectLegal("R10 entry ignored", 0);
    checkEq("R10 busy in low power", busy, 1);
    issue(CMD_MRS, 0, 0, 1'b0);  expectLegal("R10 held ignored", 0);
    issue(CMD_ACT, 0, 0, 1'b1);  expectLegal("R10 exit ignored", 0);
    checkEq("R10 no state change", bankState, 0);
    checkEq("R10 busy cleared", busy, 0);
    issue(CMD_ACT, 0, 0);        checkEq("R10 act after exit", bankState, 4'b0001);
    issue(CMD_READ, 0, 0, 1'b0); expectLegal("R10 open bank no entry", 3);
    checkEq("R10 not busy with open bank", busy, 0);
    issue(CMD_PRE, 0, 0);        checkEq("R10 cleanup", bankState, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R12: actual 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testDecode();
    testBankFlow();
    testWriteRecovery();
    testRefresh();
    testModeSet();
    testBurstStop();
    testLowPower();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule